// File: doc/BRIEF.md
# Pin Change Interrupt and Wake Unit

This unit watches a vector of external input pins and raises a single sticky interrupt request whenever any pin whose enable bit is set changes level, in either direction. Each pin is brought into the clock domain through a two-stage synchronizer and compared against the value it held one clock earlier. The request remains high until software acknowledges it. Because the previous-value copy refreshes on every clock, a pin that settles at a new level produces only one request.

Four registers on a small write/read bus hold the per-pin settings. Two carry the enable bits and two carry the weak pull-up bits, each pair split into a low and a high segment. The unit drives a per-pin pull-up enable toward the pads, masked so that a pin marked as a digital output never has its pull-up on.

When the system requests sleep, the unit captures a reference copy of the pins. While sleep is held, a purely combinational mismatch between the live pins and that reference drives a wake output, so no running clock is needed. The same mismatch is resynchronized and sets the interrupt flag once the clock runs again.

Top module: `cn_wake_unit`

## Requirements
- R1: A rising or a falling level change on an enabled pin sets `irq_out` at the third rising clock edge after the change reaches `pins_in`.
- R2: A level change on a pin whose enable bit is 0 does not set `irq_out`.
- R3: `irq_out` stays high until a clock edge with `irq_ack` high and no new change. When a change and `irq_ack` fall on the same edge, the flag is set.
- R4: A pin that holds its new level after an acknowledged change does not raise `irq_out` again.
- R5: Register map on `bus_addr`: 0 = enable bits for pins 15..0, 1 = enable bits for pins 30..16 in data bits 14..0, 2 = pull-up bits for pins 15..0, 3 = pull-up bits for pins 30..16. Writes take effect at the edge where `bus_we` is high. `bus_rdata` shows the addressed register one edge after the address is applied. Data bit 15 of addresses 1 and 3 is not stored and reads 0.
- R6: After reset, all enable and pull-up bits are 0, and `irq_out`, `pullup_en`, `wake_out` and `bus_rdata` are 0.
- R7: `pullup_en` equals the pull-up bits ANDed with the inverse of `pin_is_out`, registered one edge after either changes.
- R8: On the first edge with `sleep_mode` high, the synchronized pins are captured as a reference. While `sleep_mode` stays high, `wake_out` is high, with no clock running, exactly when some enabled pin differs from its reference.
- R9: A wake mismatch that is present while the clock runs is resynchronized and sets `irq_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (may be stopped during sleep) |
| rst | input | 1 | Synchronous active-high reset |
| pins_in | input | 31 | External pin levels, asynchronous |
| pin_is_out | input | 31 | 1 where the pin is configured as a digital output |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Registered read data |
| irq_ack | input | 1 | Clears the interrupt flag |
| sleep_mode | input | 1 | High while the device sleeps |
| irq_out | output | 1 | Sticky interrupt request |
| pullup_en | output | 31 | Per-pin pull-up enable toward the pads |
| wake_out | output | 1 | Asynchronous wake indication |

## Verification
The bench targets these corner cases:
- Falling changes as well as rising ones. A detector that only sees rising changes would leave the flag low after a fall.
- Disabled pins sitting in the upper segment next to enabled ones. A wrong segment split would raise the flag for them.
- A pin held steady after an acknowledge, which must not raise the flag again.
- An acknowledge on the same edge as a new change. A design that gives the clear priority would lose that event.
- Read-back of the unstored top bit in the upper registers, which must return 0.
- Pull-up masking by pin direction.
- Sleep with the clock actually halted. A wake path that depends on the clock would never assert `wake_out`.

// File: rtl/cn_pkg.sv
`timescale 1ns/1ps
package cn_pkg;
  localparam int SEG_W = 16;

  typedef enum logic {
    KIND_EN = 1'b0,
    KIND_PU = 1'b1
  } reg_kind_e;

  function automatic int seg_count(input int n, input int w);
    return (n + w - 1) / w;
  endfunction
endpackage

// File: rtl/cn_regfile.sv
`timescale 1ns/1ps
module cn_regfile #(
  parameter int NPINS    = 31,
  parameter int SEG_W    = 16,
  parameter int NSEG     = 2,
  parameter int SEG_BITS = 1,
  parameter int ADDR_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [SEG_W-1:0]  bus_wdata,
  output logic [SEG_W-1:0]  bus_rdata,
  output logic [NPINS-1:0]  en_bits,
  output logic [NPINS-1:0]  pu_bits
);
  import cn_pkg::*;
  localparam int PW = NSEG * SEG_W;

  function automatic logic [PW-1:0] impl_mask();
    logic [PW-1:0] m;
    for (int i = 0; i < PW; i++) m[i] = (i < NPINS);
    return m;
  endfunction
  localparam logic [PW-1:0] IMPL = impl_mask();

  logic [SEG_W-1:0] en_seg [NSEG];
  logic [SEG_W-1:0] pu_seg [NSEG];
  logic [PW-1:0]    en_flat, pu_flat;

  reg_kind_e            kind;
  logic [SEG_BITS-1:0]  seg;
  assign kind = reg_kind_e'(bus_addr[ADDR_W-1]);
  assign seg  = bus_addr[SEG_BITS-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSEG; i++) begin
        en_seg[i] <= '0;
        pu_seg[i] <= '0;
      end
    end else if (bus_we) begin
      for (int i = 0; i < NSEG; i++) begin
        if (seg == SEG_BITS'(i)) begin
          if (kind == KIND_EN) en_seg[i] <= bus_wdata & IMPL[i*SEG_W +: SEG_W];
          else                 pu_seg[i] <= bus_wdata & IMPL[i*SEG_W +: SEG_W];
        end
      end
    end
  end

  for (genvar g = 0; g < NSEG; g++) begin : g_flat
    assign en_flat[g*SEG_W +: SEG_W] = en_seg[g];
    assign pu_flat[g*SEG_W +: SEG_W] = pu_seg[g];
  end

  assign en_bits = en_flat[NPINS-1:0];
  assign pu_bits = pu_flat[NPINS-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      bus_rdata <= '0;
      for (int i = 0; i < NSEG; i++) begin
        if (seg == SEG_BITS'(i))
          bus_rdata <= (kind == KIND_EN) ? en_seg[i] : pu_seg[i];
      end
    end
  end

  // R5: storage beyond the last pin is never set
  always_comb begin
    p_pad_zero_r5: assert (((en_flat | pu_flat) & ~IMPL) == '0);
  end
endmodule

// File: rtl/cn_change_det.sv
`timescale 1ns/1ps
module cn_change_det #(
  parameter int NPINS = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pins_in,
  input  logic [NPINS-1:0] en_bits,
  input  logic             irq_ack,
  input  logic             wake_raw,
  output logic [NPINS-1:0] pins_sync,
  output logic             irq_flag
);
  logic [NPINS-1:0] sync_a, sync_b, prev;
  logic             wake_a, wake_b;
  logic             set_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_a <= '0;
      sync_b <= '0;
      prev   <= '0;
      wake_a <= 1'b0;
      wake_b <= 1'b0;
    end else begin
      sync_a <= pins_in;
      sync_b <= sync_a;
      prev   <= sync_b;
      wake_a <= wake_raw;
      wake_b <= wake_a;
    end
  end

  assign set_evt   = (|((sync_b ^ prev) & en_bits)) | wake_b;
  assign pins_sync = sync_b;

  always_ff @(posedge clk) begin
    if (rst)          irq_flag <= 1'b0;
    else if (set_evt) irq_flag <= 1'b1;
    else if (irq_ack) irq_flag <= 1'b0;
  end

  p_set_wins_r1: assert property (@(posedge clk) disable iff (rst)
    set_evt |=> irq_flag);
  p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (irq_flag && !irq_ack) |=> irq_flag);
  p_ack_clears_r3: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !set_evt) |=> !irq_flag);
endmodule

// File: rtl/cn_sleep_wake.sv
`timescale 1ns/1ps
module cn_sleep_wake #(
  parameter int NPINS = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep_mode,
  input  logic [NPINS-1:0] pins_in,
  input  logic [NPINS-1:0] pins_sync,
  input  logic [NPINS-1:0] en_bits,
  output logic             wake_raw
);
  logic             sleep_q;
  logic [NPINS-1:0] ref_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      sleep_q <= 1'b0;
      ref_lvl <= '0;
    end else begin
      sleep_q <= sleep_mode;
      if (sleep_mode && !sleep_q) ref_lvl <= pins_sync;
    end
  end

  // combinational on purpose: must work with the clock halted
  assign wake_raw = sleep_mode & sleep_q & (|((pins_in ^ ref_lvl) & en_bits));

  p_entry_capture_r8: assert property (@(posedge clk) disable iff (rst)
    (sleep_mode && !sleep_q) |=> (ref_lvl == $past(pins_sync)));
endmodule

// File: rtl/cn_wake_unit.sv
`timescale 1ns/1ps
module cn_wake_unit #(
  parameter int NPINS = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pins_in,
  input  logic [NPINS-1:0] pin_is_out,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [15:0]      bus_wdata,
  output logic [15:0]      bus_rdata,
  input  logic             irq_ack,
  input  logic             sleep_mode,
  output logic             irq_out,
  output logic [NPINS-1:0] pullup_en,
  output logic             wake_out
);
  import cn_pkg::*;
  localparam int NSEG     = seg_count(NPINS, SEG_W);
  localparam int SEG_BITS = (NSEG > 1) ? $clog2(NSEG) : 1;
  localparam int ADDR_W   = SEG_BITS + 1;

  logic [NPINS-1:0]  en_bits, pu_bits, pins_sync;
  logic [ADDR_W-1:0] addr_int;
  logic              wake_raw;

  assign addr_int = ADDR_W'(bus_addr);

  cn_regfile #(.NPINS(NPINS), .SEG_W(SEG_W), .NSEG(NSEG),
               .SEG_BITS(SEG_BITS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(addr_int),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .en_bits(en_bits), .pu_bits(pu_bits));

  cn_change_det #(.NPINS(NPINS)) u_det (
    .clk(clk), .rst(rst), .pins_in(pins_in), .en_bits(en_bits),
    .irq_ack(irq_ack), .wake_raw(wake_raw), .pins_sync(pins_sync),
    .irq_flag(irq_out));

  cn_sleep_wake #(.NPINS(NPINS)) u_sleep (
    .clk(clk), .rst(rst), .sleep_mode(sleep_mode), .pins_in(pins_in),
    .pins_sync(pins_sync), .en_bits(en_bits), .wake_raw(wake_raw));

  assign wake_out = wake_raw;

  always_ff @(posedge clk) begin
    if (rst) pullup_en <= '0;
    else     pullup_en <= pu_bits & ~pin_is_out;
  end

  p_pullup_mask_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pullup_en & $past(pin_is_out)) == '0));
endmodule

// File: tb/cn_wake_unit_test.sv
`timescale 1ns/1ps
module cn_wake_unit_test;
  logic        clk = 1'b0;
  logic        clk_run = 1'b1;
  logic        rst;
  logic [30:0] pins_in, pin_is_out;
  logic        bus_we, irq_ack, sleep_mode;
  logic [1:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        irq_out, wake_out;
  logic [30:0] pullup_en;

  int errors = 0;
  int checks = 0;

  always #4 if (clk_run) clk = ~clk;

  cn_wake_unit uut (
    .clk(clk), .rst(rst), .pins_in(pins_in), .pin_is_out(pin_is_out),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_ack(irq_ack), .sleep_mode(sleep_mode),
    .irq_out(irq_out), .pullup_en(pullup_en), .wake_out(wake_out));

  // {expected irq, pin vector}; enables: pins 23..0 on, 30..24 off
  localparam logic [31:0] VEC [8] = '{
    {1'b1, 31'h0000_0001},   // R1 rise pin0
    {1'b1, 31'h0000_0000},   // R1 fall pin0
    {1'b0, 31'h4000_0000},   // R2 pin30 disabled
    {1'b1, 31'h4080_0000},   // R1 pin23
    {1'b0, 31'h4080_0000},   // R4 held level
    {1'b0, 31'h4180_0000},   // R2 pin24 disabled
    {1'b1, 31'h0000_0000},   // R1 pin23 falls
    {1'b1, 31'h0001_0000}    // R1 pin16
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_check(input logic [1:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    check(req, {16'h0, bus_rdata}, {16'h0, exp});
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; pins_in = '0; pin_is_out = '0; bus_we = 1'b0;
    bus_addr = '0; bus_wdata = '0; irq_ack = 1'b0; sleep_mode = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R6 irq", {31'h0, irq_out}, 32'h0);
    check("R6 pullup", {1'b0, pullup_en}, 32'h0);
    check("R6 wake", {31'h0, wake_out}, 32'h0);
    check("R6 rdata", {16'h0, bus_rdata}, 32'h0);
    rst = 1'b0;
    rd_check(2'd1, 16'h0000, "R6 enable reset");

    // R5 register map and unstored bit
    wr(2'd1, 16'hFFFF);
    rd_check(2'd1, 16'h7FFF, "R5 high enable bit15 reads 0");
    wr(2'd3, 16'hFFFF);
    rd_check(2'd3, 16'h7FFF, "R5 high pull-up bit15 reads 0");
    wr(2'd3, 16'h0000);
    wr(2'd0, 16'hFFFF);
    wr(2'd1, 16'h00FF);
    rd_check(2'd0, 16'hFFFF, "R5 low enable");

    // R7 pull-up masking
    pin_is_out = 31'h0000_0030;
    wr(2'd2, 16'h00F0);
    @(negedge clk);
    check("R7 masked pull-ups", {1'b0, pullup_en}, 32'h0000_00C0);
    pin_is_out = '0;
    @(negedge clk);
    check("R7 unmasked pull-ups", {1'b0, pullup_en}, 32'h0000_00F0);

    // vector table: R1, R2, R4
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      pins_in = VEC[i][30:0];
      repeat (3) @(posedge clk);
      @(negedge clk);
      check($sformatf("R1/R2/R4 vector %0d", i), {31'h0, irq_out}, {31'h0, VEC[i][31]});
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;
      check($sformatf("R3 cleared after ack %0d", i), {31'h0, irq_out}, 32'h0);
    end

    // R3 change and ack on the same edge
    @(negedge clk);
    irq_ack = 1'b1;
    pins_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R3 set beats ack", {31'h0, irq_out}, 32'h1);
    @(negedge clk);
    check("R3 ack clears afterwards", {31'h0, irq_out}, 32'h0);
    irq_ack = 1'b0;

    // R8 sleep with the clock halted
    @(negedge clk);
    sleep_mode = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 no wake at entry", {31'h0, wake_out}, 32'h0);
    clk_run = 1'b0;
    #20;
    pins_in[30] = 1'b1;
    #5;
    check("R8 disabled pin no wake", {31'h0, wake_out}, 32'h0);
    pins_in[0] = 1'b1;
    #5;
    check("R8 wake without clock", {31'h0, wake_out}, 32'h1);
    clk_run = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R9 irq after clock restarts", {31'h0, irq_out}, 32'h1);
    sleep_mode = 1'b0;
    #1;
    check("R8 wake drops on leaving sleep", {31'h0, wake_out}, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule